// File: doc/BRIEF.md
# Four-Pin SPI Controller with Bus-Enable Input

This block is a byte-wide SPI engine that can act as bus master or as a slave. A fourth pad, the bus-enable input, can be set to be ignored, active-high or active-low. In master mode this input detects a competing master. When it goes inactive, the controller stops driving the clock and data pads, drops the byte it was shifting, and raises a sticky frame-error flag. In slave mode the same input is the select line from the remote master. While it is inactive, shifting is frozen and the slave's data pad is released. When it becomes active again, the transfer resumes at the bit where it stopped.

Software side: a one-byte transmit holding register and a one-byte receive holding register. Status signals report transmit empty, receive full, busy, frame error and overrun. Two single-cycle interrupt pulses are provided. The transmit pulse fires when the holding byte moves into the shift register, so software can queue the next byte while the current one is still on the wire. A listen option feeds the outgoing bit stream back into the receiver. The receive pulse then marks the moment a whole byte has left the line.

Every pad is split into a value, an output enable and, where needed, an input. The pad ring builds the tristate drivers. Data moves MSB first. The clock idles low, data changes on the falling edge and is sampled on the rising edge. The master clock half period is set by a programmable divider.

Top module: `spi4_ctrl`

## Requirements
- R1: After reset, tx_empty is 1, and rx_full, busy, frame_err, overrun, tx_irq, rx_irq and sclk_o are 0.
- R2: In master mode a byte written through tx_wr is sent on mosi_o MSB first. sclk_o idles low, mosi_o changes after falling edges, and miso_i is sampled on rising edges into the received byte, MSB first.
- R3: In master mode each sclk_o half period lasts cfg_div+1 clock cycles, so consecutive rising edges are 2*(cfg_div+1) cycles apart.
- R4: tx_irq pulses for one cycle when the holding byte is moved into the shift register. At that point tx_empty is 1 and busy is 1, before the byte's rx_irq. This applies in both master and slave mode.
- R5: When the eighth bit completes, rx_irq pulses, rx_full becomes 1 and rx_data holds the byte. A pulse on rx_rd clears rx_full.
- R6: If a byte completes while rx_full is still 1, overrun becomes 1 and rx_data takes the new byte. overrun stays set until err_clr.
- R7: With cfg_listen set, the receiver takes the controller's own outgoing bits instead of the data input pad, so rx_data equals the transmitted byte.
- R8: cfg_mode encodes the bus-enable input: 2'b00 (and 2'b11) ignore it, 2'b01 makes it active when high, and 2'b10 makes it active when low.
- R9: In master mode with a four-pin encoding, sclk_oe and mosi_oe are 1 only while the bus-enable input is active. miso_oe is 0 in master mode.
- R10: In master mode with a four-pin encoding, the bus-enable input turning from active to inactive sets frame_err. frame_err stays 1, also after the input is active again, until err_clr.
- R11: In master mode, the bus-enable input going inactive aborts the byte in progress. busy drops, no rx_irq follows, rx_full is unchanged, and the next queued byte transfers in full.
- R12: In slave mode the block receives mosi_i on rising sclk_i edges and sends its queued byte MSB first on miso_o. miso_oe is 1 only while the bus-enable input is active, and sclk_oe and mosi_oe are 0.
- R13: In slave mode, while the bus-enable input is inactive, sclk_i edges are ignored, miso_oe is 0 and the partial byte is kept. Once the input is active again, the remaining bits complete the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 selects master, 0 selects slave |
| cfg_mode | input | 2 | Bus-enable encoding (see R8) |
| cfg_listen | input | 1 | Internal loopback of outgoing bits to the receiver |
| cfg_div | input | DIV_W | Master half-period minus one, in clock cycles |
| tx_wr | input | 1 | Write pulse for the transmit holding byte |
| tx_data | input | DW | Byte written by tx_wr |
| rx_rd | input | 1 | Read pulse, clears rx_full |
| err_clr | input | 1 | Clears frame_err and overrun |
| rx_data | output | DW | Receive holding byte |
| tx_empty | output | 1 | Transmit holding register free |
| rx_full | output | 1 | Receive holding register has an unread byte |
| busy | output | 1 | A byte is in the shift register |
| frame_err | output | 1 | Sticky competing-master flag |
| overrun | output | 1 | Sticky unread-byte-overwritten flag |
| tx_irq | output | 1 | Pulse: holding byte moved to shifter |
| rx_irq | output | 1 | Pulse: byte received |
| sclk_i | input | 1 | Serial clock pad input (slave) |
| sclk_o | output | 1 | Serial clock pad value (master) |
| sclk_oe | output | 1 | Serial clock pad drive enable |
| mosi_i | input | 1 | Master-out data pad input (slave) |
| mosi_o | output | 1 | Master-out data pad value |
| mosi_oe | output | 1 | Master-out data pad drive enable |
| miso_i | input | 1 | Slave-out data pad input (master) |
| miso_o | output | 1 | Slave-out data pad value |
| miso_oe | output | 1 | Slave-out data pad drive enable |
| en_pin_i | input | 1 | Bus-enable pad input |

## Verification
The embedded properties assume the configuration inputs change only while no byte is in the shift register. They also assume the slave-side pads move slowly compared with the two-stage input synchronizer. The stimulus meets both conditions. Mode, role and divider are set only between bytes. Enable-input changes are ordered so that switching encodings never produces an active-to-inactive edge. The bench's remote master holds each level of sclk_i, mosi_i and the enable input for at least six clock cycles, and it samples miso_o just before it raises sclk_i.

// File: rtl/spi4_pkg.sv
package spi4_pkg;
    typedef enum logic [1:0] {
        PINS3     = 2'b00,
        PINS4_HI  = 2'b01,
        PINS4_LO  = 2'b10,
        PINS3_ALT = 2'b11
    } pin_mode_e;
endpackage

// File: rtl/spi4_sync.sv
module spi4_sync #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = d_i;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign q_o = r_q.s2;
endmodule

// File: rtl/spi4_clkgen.sv
module spi4_clkgen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
    } cg_t;

    cg_t r_q, r_d;
    logic wrap;

    always_comb begin
        r_d  = r_q;
        wrap = run && (r_q.cnt == div);
        if (!run) begin
            r_d.cnt  = '0;
            r_d.sclk = 1'b0;
        end else if (wrap) begin
            r_d.cnt  = '0;
            r_d.sclk = ~r_q.sclk;
        end else begin
            r_d.cnt  = r_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sclk = r_q.sclk;
    assign rise = wrap && !r_q.sclk;
    assign fall = wrap &&  r_q.sclk;

    // R2: a stopped generator leaves the clock low
    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !r_q.sclk);
    // R3: the level only moves when the divider count wraps
    a_r3_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && r_q.cnt != '0 |-> $stable(r_q.sclk));
endmodule

// File: rtl/spi4_shifter.sv
module spi4_shifter #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_master,
    input  logic          active,
    input  logic          rise,
    input  logic          fall,
    input  logic          in_bit,
    input  logic          load_req,
    input  logic [DW-1:0] load_data,
    output logic          out_bit,
    output logic          load_ack,
    output logic          done,
    output logic [DW-1:0] rx_byte,
    output logic          busy
);
    localparam int unsigned CW = (DW > 1) ? $clog2(DW) : 1;

    typedef struct packed {
        logic [DW-1:0] sh;
        logic          cap;
        logic [CW-1:0] cnt;
        logic          loaded;
    } sh_t;

    sh_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        load_ack = 1'b0;
        done     = 1'b0;
        rx_byte  = {r_q.sh[DW-2:0], r_q.cap};
        if (is_master && !active) begin
            r_d.loaded = 1'b0;
            r_d.cnt    = '0;
            r_d.cap    = 1'b0;
            r_d.sh     = '0;
        end else if (active) begin
            if (!r_q.loaded && r_q.cnt == '0 && load_req && !fall) begin
                r_d.sh     = load_data;
                r_d.loaded = 1'b1;
                load_ack   = 1'b1;
            end
            if (rise) r_d.cap = in_bit;
            if (fall) begin
                r_d.sh  = {r_q.sh[DW-2:0], r_q.cap};
                r_d.cnt = r_q.cnt + CW'(1);
                if (r_q.cnt == CW'(DW-1)) begin
                    done       = 1'b1;
                    r_d.cnt    = '0;
                    r_d.loaded = 1'b0;
                    r_d.sh     = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_bit = r_q.sh[DW-1];
    assign busy    = r_q.loaded || (r_q.cnt != '0);

    // R13: an inactive slave keeps its partial byte untouched
    a_r13_slave_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master && !active |=> $stable(r_q.sh) && $stable(r_q.cnt));
    // R11: a master that loses the bus ends up idle
    a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        is_master && !active |=> !busy);
endmodule

// File: rtl/spi4_ctrl.sv
module spi4_ctrl #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_master,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_listen,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             tx_wr,
    input  logic [DW-1:0]    tx_data,
    input  logic             rx_rd,
    input  logic             err_clr,
    output logic [DW-1:0]    rx_data,
    output logic             tx_empty,
    output logic             rx_full,
    output logic             busy,
    output logic             frame_err,
    output logic             overrun,
    output logic             tx_irq,
    output logic             rx_irq,
    input  logic             sclk_i,
    output logic             sclk_o,
    output logic             sclk_oe,
    input  logic             mosi_i,
    output logic             mosi_o,
    output logic             mosi_oe,
    input  logic             miso_i,
    output logic             miso_o,
    output logic             miso_oe,
    input  logic             en_pin_i
);
    typedef struct packed {
        logic [DW-1:0] tx_buf;
        logic          tx_full;
        logic [DW-1:0] rx_buf;
        logic          rx_full;
        logic          ferr;
        logic          ovr;
        logic          tx_irq;
        logic          rx_irq;
        logic          act_prev;
        logic          sclk_prev;
    } ctl_t;

    ctl_t r_q, r_d;

    logic [2:0]    sync_q;
    logic          sclk_s, mosi_s, en_s;
    logic          four_pin, act;
    logic          cg_sclk, cg_rise, cg_fall, run;
    logic          rise, fall, in_bit, out_bit;
    logic          load_ack, done, sh_busy;
    logic [DW-1:0] rx_byte;

    spi4_sync #(.W(3)) sync_i (
        .clk (clk),
        .rst_n (rst_n),
        .d_i ({en_pin_i, mosi_i, sclk_i}),
        .q_o (sync_q)
    );
    assign {en_s, mosi_s, sclk_s} = sync_q;

    assign four_pin = (cfg_mode == spi4_pkg::PINS4_HI) || (cfg_mode == spi4_pkg::PINS4_LO);
    assign act      = !four_pin || (en_s ^ (cfg_mode == spi4_pkg::PINS4_LO));
    assign run      = cfg_master && sh_busy && act;

    spi4_clkgen #(.DIV_W(DIV_W)) clkgen_i (
        .clk (clk),
        .rst_n (rst_n),
        .run (run),
        .div (cfg_div),
        .sclk (cg_sclk),
        .rise (cg_rise),
        .fall (cg_fall)
    );

    assign rise   = cfg_master ? cg_rise : (sclk_s && !r_q.sclk_prev);
    assign fall   = cfg_master ? cg_fall : (!sclk_s && r_q.sclk_prev);
    assign in_bit = cfg_listen ? out_bit : (cfg_master ? miso_i : mosi_s);

    spi4_shifter #(.DW(DW)) shifter_i (
        .clk (clk),
        .rst_n (rst_n),
        .is_master (cfg_master),
        .active (act),
        .rise (rise),
        .fall (fall),
        .in_bit (in_bit),
        .load_req (r_q.tx_full),
        .load_data (r_q.tx_buf),
        .out_bit (out_bit),
        .load_ack (load_ack),
        .done (done),
        .rx_byte (rx_byte),
        .busy (sh_busy)
    );

    always_comb begin
        r_d           = r_q;
        r_d.act_prev  = act;
        r_d.sclk_prev = sclk_s;
        r_d.tx_irq    = load_ack;
        r_d.rx_irq    = done;
        if (tx_wr) r_d.tx_buf = tx_data;
        r_d.tx_full = tx_wr || (r_q.tx_full && !load_ack);
        if (err_clr) begin
            r_d.ferr = 1'b0;
            r_d.ovr  = 1'b0;
        end
        if (done) begin
            r_d.rx_buf  = rx_byte;
            r_d.rx_full = 1'b1;
            if (r_q.rx_full && !rx_rd) r_d.ovr = 1'b1;
        end else if (rx_rd) begin
            r_d.rx_full = 1'b0;
        end
        if (cfg_master && four_pin && r_q.act_prev && !act) r_d.ferr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_data   = r_q.rx_buf;
    assign tx_empty  = !r_q.tx_full;
    assign rx_full   = r_q.rx_full;
    assign busy      = sh_busy;
    assign frame_err = r_q.ferr;
    assign overrun   = r_q.ovr;
    assign tx_irq    = r_q.tx_irq;
    assign rx_irq    = r_q.rx_irq;
    assign sclk_o    = cg_sclk;
    assign sclk_oe   = cfg_master && act;
    assign mosi_o    = out_bit;
    assign mosi_oe   = cfg_master && act;
    assign miso_o    = out_bit;
    assign miso_oe   = !cfg_master && act;

    // R10: frame error is held until software clears it
    a_r10_ferr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err && !err_clr |=> frame_err);
    // R6: overrun is held until software clears it
    a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !err_clr |=> overrun);
    // R11: losing the bus never delivers a partial byte
    a_r11_no_rx_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_master && four_pin && r_q.act_prev && !act |=> !rx_irq);
    // R4: the transmit interrupt is a single-cycle pulse
    a_r4_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);
    // R5: a receive pulse always comes with a full holding register
    a_r5_irq_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full);
endmodule

// File: tb/spi4_ctrl_tb_top.sv
module spi4_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_master = 1'b1;
    logic [1:0] cfg_mode = 2'b00;
    logic       cfg_listen = 1'b0;
    logic [7:0] cfg_div = 8'd1;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       rx_rd = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       tx_empty, rx_full, busy, frame_err, overrun, tx_irq, rx_irq;
    logic       sclk_i = 1'b0, mosi_i = 1'b0, en_pin_i = 1'b0;
    logic       sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic       miso_i;

    int errors = 0;
    int checks = 0;

    logic [7:0] mdl_byte = 8'h00;
    logic       mdl_load = 1'b0;
    logic [7:0] mdl_sh;
    logic [7:0] mosi_cap;

    always #5 clk = ~clk;

    spi4_ctrl dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_master (cfg_master), .cfg_mode (cfg_mode), .cfg_listen (cfg_listen),
        .cfg_div (cfg_div), .tx_wr (tx_wr), .tx_data (tx_data), .rx_rd (rx_rd),
        .err_clr (err_clr), .rx_data (rx_data), .tx_empty (tx_empty),
        .rx_full (rx_full), .busy (busy), .frame_err (frame_err), .overrun (overrun),
        .tx_irq (tx_irq), .rx_irq (rx_irq),
        .sclk_i (sclk_i), .sclk_o (sclk_o), .sclk_oe (sclk_oe),
        .mosi_i (mosi_i), .mosi_o (mosi_o), .mosi_oe (mosi_oe),
        .miso_i (miso_i), .miso_o (miso_o), .miso_oe (miso_oe),
        .en_pin_i (en_pin_i)
    );

    // remote slave model for master tests
    always @(negedge sclk_o or posedge mdl_load) begin
        if (mdl_load) mdl_sh <= mdl_byte;
        else          mdl_sh <= {mdl_sh[6:0], 1'b0};
    end
    assign miso_i = mdl_sh[7];

    always @(posedge sclk_o) mosi_cap <= {mosi_cap[6:0], mosi_o};

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_tx(input logic [7:0] b);
        @(negedge clk) tx_data = b; tx_wr = 1'b1;
        @(negedge clk) tx_wr = 1'b0;
    endtask

    task automatic read_rx(input string req);
        @(negedge clk) rx_rd = 1'b1;
        @(negedge clk) rx_rd = 1'b0;
        check({req, " rx_full cleared by read"}, rx_full, 0);
    endtask

    task automatic clear_err();
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1 tx_empty", tx_empty, 1);
        check("R1 rx_full", rx_full, 0);
        check("R1 busy", busy, 0);
        check("R1 frame_err", frame_err, 0);
        check("R1 overrun", overrun, 0);
        check("R1 irqs", {tx_irq, rx_irq}, 0);
        check("R1 sclk_o", sclk_o, 0);
    endtask

    task automatic master_xfer(input string req, input logic [7:0] tx, input logic [7:0] mdl,
                               input logic [7:0] exp_rx, input logic exp_ovr);
        int tx_at = -1;
        int rx_at = -1;
        mdl_byte = mdl;
        @(negedge clk) mdl_load = 1'b1;
        @(negedge clk) mdl_load = 1'b0;
        write_tx(tx);
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if (tx_irq && tx_at < 0) begin
                tx_at = c;
                check({req, " R4 tx_empty at tx_irq"}, tx_empty, 1);
                check({req, " R4 busy at tx_irq"}, busy, 1);
            end
            if (rx_irq) begin
                rx_at = c;
                break;
            end
        end
        check({req, " R4 tx_irq before rx_irq"}, (tx_at >= 0) && (rx_at > tx_at), 1);
        check({req, " R2 mosi bits MSB first"}, mosi_cap, tx);
        check({req, " R5 rx_data"}, rx_data, exp_rx);
        check({req, " R5 rx_full"}, rx_full, 1);
        check({req, " R6 overrun"}, overrun, exp_ovr);
        check({req, " R2 sclk idle low"}, sclk_o, 0);
    endtask

    task automatic t_period(input logic [7:0] div);
        int first = -1;
        int second = -1;
        logic prev;
        cfg_div = div;
        write_tx(8'h5C);
        prev = sclk_o;
        for (int c = 0; c < 4000 && second < 0; c++) begin
            @(negedge clk);
            if (sclk_o && !prev) begin
                if (first < 0) first = c;
                else second = c;
            end
            prev = sclk_o;
        end
        check("R3 rising-edge spacing", second - first, 2 * (int'(div) + 1));
        for (int c = 0; c < 4000 && !rx_full; c++) @(negedge clk);
        read_rx("R3");
    endtask

    task automatic t_overrun();
        master_xfer("R6 first", 8'h11, 8'h22, 8'h22, 1'b0);
        master_xfer("R6 second", 8'h33, 8'h44, 8'h44, 1'b1);
        cyc(5);
        check("R6 overrun still set", overrun, 1);
        clear_err();
        check("R6 overrun cleared", overrun, 0);
        read_rx("R6");
    endtask

    task automatic t_abort();
        cfg_mode = 2'b00;
        en_pin_i = 1'b1;
        cyc(4);
        cfg_mode = 2'b01;
        cfg_div = 8'd3;
        cyc(2);
        check("R9 drivers on while enable active", {sclk_oe, mosi_oe, miso_oe}, 3'b110);
        mdl_byte = 8'hFF;
        @(negedge clk) mdl_load = 1'b1;
        @(negedge clk) mdl_load = 1'b0;
        write_tx(8'hE7);
        cyc(20);
        check("R11 busy mid-byte", busy, 1);
        en_pin_i = 1'b0;
        cyc(4);
        check("R9 sclk_oe released", sclk_oe, 0);
        check("R9 mosi_oe released", mosi_oe, 0);
        check("R10 frame_err set", frame_err, 1);
        check("R11 busy dropped", busy, 0);
        cyc(100);
        check("R11 no partial byte delivered", rx_full, 0);
        en_pin_i = 1'b1;
        cyc(6);
        check("R10 frame_err sticky after re-activation", frame_err, 1);
        clear_err();
        check("R10 frame_err cleared", frame_err, 0);
        master_xfer("R11 after abort", 8'h9D, 8'h62, 8'h62, 1'b0);
        check("R11 frame_err stays clear", frame_err, 0);
        read_rx("R11");
    endtask

    task automatic slave_xfer(input string req, input logic [7:0] mb, input logic [7:0] stx,
                              input logic halt);
        logic [7:0] got;
        got = 8'h00;
        write_tx(stx);
        cyc(4);
        check({req, " R12 miso_oe active"}, miso_oe, 1);
        check({req, " R12 master drivers off"}, {sclk_oe, mosi_oe}, 2'b00);
        check({req, " R4 slave tx_empty after load"}, tx_empty, 1);
        for (int i = 0; i < 8; i++) begin
            mosi_i = mb[7-i];
            cyc(8);
            got[7-i] = miso_o;
            sclk_i = 1'b1;
            cyc(8);
            sclk_i = 1'b0;
            if (halt && i == 3) begin
                cyc(8);
                en_pin_i = 1'b1;
                cyc(4);
                check({req, " R13 miso_oe released"}, miso_oe, 0);
                for (int k = 0; k < 2; k++) begin
                    mosi_i = ~mosi_i;
                    sclk_i = 1'b1;
                    cyc(6);
                    sclk_i = 1'b0;
                    cyc(6);
                end
                check({req, " R13 byte held while inactive"}, {busy, rx_full}, 2'b10);
                en_pin_i = 1'b0;
                cyc(6);
            end
        end
        for (int c = 0; c < 30 && !rx_full; c++) @(negedge clk);
        check({req, " R12 miso bits"}, got, stx);
        check({req, " R12 rx_data"}, rx_data, mb);
        check({req, " R12 rx_full"}, rx_full, 1);
        check({req, " R10 no frame error in slave"}, frame_err, 0);
        read_rx(req);
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        t_reset_state();

        cfg_master = 1'b1; cfg_mode = 2'b00; cfg_div = 8'd1; en_pin_i = 1'b0;
        master_xfer("R2 pattern B4", 8'hB4, 8'h69, 8'h69, 1'b0);
        read_rx("R5 a");
        master_xfer("R2 pattern 01", 8'h01, 8'h80, 8'h80, 1'b0);
        read_rx("R5 b");

        t_period(8'd3);
        t_period(8'd0);
        cfg_div = 8'd1;

        t_overrun();

        cfg_listen = 1'b1;
        master_xfer("R7 listen", 8'hA5, 8'h00, 8'hA5, 1'b0);
        read_rx("R7");
        cfg_listen = 1'b0;

        // R8: three-pin encoding ignores the pin; active-low works with the pin low
        en_pin_i = 1'b0;
        master_xfer("R8 mode00", 8'h3E, 8'hC1, 8'hC1, 1'b0);
        check("R8 mode00 no frame error", frame_err, 0);
        read_rx("R8 a");
        cfg_mode = 2'b10;
        cyc(2);
        check("R8 R9 mode10 low is active", sclk_oe, 1);
        master_xfer("R8 mode10", 8'h72, 8'h4B, 8'h4B, 1'b0);
        read_rx("R8 b");

        t_abort();

        cfg_master = 1'b0;
        cyc(2);
        en_pin_i = 1'b0;
        cyc(4);
        cfg_mode = 2'b10;
        cyc(4);
        slave_xfer("R12 slave", 8'h5A, 8'hC3, 1'b0);
        slave_xfer("R13 slave halt", 8'h3C, 8'h96, 1'b1);

        summary();
        $finish;
    end
endmodule